// File: doc/BRIEF.md
# Memory Map Decoder with Relocatable Video Window

This block sits on the processor's address path and sorts every request into one of three destinations: the I/O space, the video frame buffer, or main memory. The I/O space is the topmost block of the address range and always wins. Any other address that falls inside the frame buffer window goes to the processor-side port of a dual-port video block RAM, which holds the frame buffer. The block delivers the byte offset into that window; the display reads the other port of the RAM. Every address left over goes to main memory, with the upper bits cleared so that all of the non-I/O space aliases into the first 1 MB.

The window start is held in a register that software writes and reads at a single I/O address. The register comes out of reset at 0x0E7F00. A new value takes effect from the next clock cycle. Software can move the window above the 8 MB boundary, which leaves addresses 0 to 8 MB as one unbroken stretch of main memory.

The decode is purely combinational. The only state is the base register. The block does not contain the video RAM, the display timing or the cache.

Top module: `vmap_decoder`

## Requirements
- R1: After reset, reading the base register at I/O address 0xFFFFE0 returns 0x0E7F00, zero-extended to 32 bits.
- R2: A request whose address bits [23:12] are all ones asserts io_sel_o only, whether or not it hits the video window.
- R3: A non-I/O request with base <= addr < base + 0x18000 asserts vid_sel_o only, and vid_off_o equals addr - base.
- R4: Any other non-I/O request asserts mem_sel_o only, and mem_addr_o equals addr with bits [23:20] forced to zero.
- R5: At most one of io_sel_o, vid_sel_o and mem_sel_o is high in any cycle, and none is high while req_i is low.
- R6: A write request (we_i high) to address 0xFFFFE0 loads wdata_i[23:0] into the base register at the clock edge. The decode uses the new window from the next cycle on.
- R7: base_hit_o is high for any request to 0xFFFFE0. While it is high, base_rdata_o carries the base zero-extended; otherwise base_rdata_o is 0.
- R8: Reads of 0xFFFFE0, and writes to any other address, leave the base register unchanged.
- R9: With the base set to 0x800000 or above, every address below 0x800000 decodes as main memory, aliased to its low 20 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request valid |
| we_i | input | 1 | Write request when high |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 32 | Write data |
| io_sel_o | output | 1 | Request targets the I/O space |
| vid_sel_o | output | 1 | Request targets the frame buffer |
| vid_off_o | output | 17 | Byte offset within the frame buffer |
| mem_sel_o | output | 1 | Request targets main memory |
| mem_addr_o | output | 24 | Aliased memory address, valid with mem_sel_o |
| base_hit_o | output | 1 | Request addresses the base register |
| base_rdata_o | output | 32 | Base register read data |

## Verification
The assertions check, on every cycle, the following:
- the selects are mutually exclusive and stay quiet when there is no request;
- I/O addresses always win;
- memory addresses arrive with their upper bits cleared;
- the base register changes only on a write to its own address, and then takes exactly the written value.

Only the bench scenarios can show the window edges relative to a moving base:
- the cycle right after a relocation;
- the case where the window sits above the 8 MB boundary or partly inside the I/O space.

The bench covers these by comparing against an independent address model.

// File: rtl/vmap_pkg.sv
package vmap_pkg;
  localparam int unsigned ADDR_W        = 24;
  localparam int unsigned DATA_W        = 32;
  localparam int unsigned MEM_AW        = 20;
  localparam int unsigned IO_AW         = 12;
  localparam int unsigned VID_BYTES     = 98304;
  localparam logic [ADDR_W-1:0] VID_RST_BASE  = 24'h0E7F00;
  localparam logic [ADDR_W-1:0] BASE_REG_ADDR = 24'hFFFFE0;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_IO   = 2'd1,
    RG_VID  = 2'd2,
    RG_MEM  = 2'd3
  } region_e;
endpackage

// File: rtl/vmap_base_reg.sv
module vmap_base_reg #(
  parameter int unsigned ADDR_W = vmap_pkg::ADDR_W,
  parameter logic [ADDR_W-1:0] RST_VAL = vmap_pkg::VID_RST_BASE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      base_o <= RST_VAL;
    else if (wr_en_i) base_o <= wdata_i;
  end
endmodule

// File: rtl/vmap_region_dec.sv
module vmap_region_dec
  import vmap_pkg::*;
#(
  parameter int unsigned ADDR_W    = vmap_pkg::ADDR_W,
  parameter int unsigned IO_AW     = vmap_pkg::IO_AW,
  parameter int unsigned VID_BYTES = vmap_pkg::VID_BYTES,
  localparam int unsigned VOFF_W   = $clog2(VID_BYTES)
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  output region_e           region_o,
  output logic [VOFF_W-1:0] vid_off_o
);
  localparam logic [ADDR_W:0] VID_LIM = (ADDR_W+1)'(VID_BYTES);

  logic [ADDR_W:0] diff;
  logic            in_io, in_vid;

  // extra bit catches addr < base as a borrow
  assign diff   = {1'b0, addr_i} - {1'b0, base_i};
  assign in_io  = &addr_i[ADDR_W-1:IO_AW];
  assign in_vid = !diff[ADDR_W] && (diff < VID_LIM);

  always_comb begin
    if (!req_i)      region_o = RG_NONE;
    else if (in_io)  region_o = RG_IO;
    else if (in_vid) region_o = RG_VID;
    else             region_o = RG_MEM;
  end

  assign vid_off_o = diff[VOFF_W-1:0];
endmodule

// File: rtl/vmap_alias.sv
module vmap_alias #(
  parameter int unsigned ADDR_W = vmap_pkg::ADDR_W,
  parameter int unsigned MEM_AW = vmap_pkg::MEM_AW
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] mem_addr_o
);
  generate
    if (MEM_AW < ADDR_W) begin : g_fold
      logic unused_hi;
      assign unused_hi  = ^addr_i[ADDR_W-1:MEM_AW];
      assign mem_addr_o = {{(ADDR_W-MEM_AW){1'b0}}, addr_i[MEM_AW-1:0]};
    end else begin : g_pass
      assign mem_addr_o = addr_i;
    end
  endgenerate
endmodule

// File: rtl/vmap_decoder.sv
module vmap_decoder
  import vmap_pkg::*;
#(
  parameter int unsigned ADDR_W    = vmap_pkg::ADDR_W,
  parameter int unsigned DATA_W    = vmap_pkg::DATA_W,
  parameter int unsigned MEM_AW    = vmap_pkg::MEM_AW,
  parameter int unsigned IO_AW     = vmap_pkg::IO_AW,
  parameter int unsigned VID_BYTES = vmap_pkg::VID_BYTES,
  parameter logic [ADDR_W-1:0] VID_RST_BASE  = vmap_pkg::VID_RST_BASE,
  parameter logic [ADDR_W-1:0] BASE_REG_ADDR = vmap_pkg::BASE_REG_ADDR,
  localparam int unsigned VOFF_W = $clog2(VID_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              io_sel_o,
  output logic              vid_sel_o,
  output logic [VOFF_W-1:0] vid_off_o,
  output logic              mem_sel_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              base_hit_o,
  output logic [DATA_W-1:0] base_rdata_o
);
  logic [ADDR_W-1:0] vid_base;
  region_e           region;
  logic              base_wr;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DATA_W-1:ADDR_W];

  assign base_hit_o   = req_i && (addr_i == BASE_REG_ADDR);
  assign base_wr      = base_hit_o && we_i;
  assign base_rdata_o = base_hit_o ? {{(DATA_W-ADDR_W){1'b0}}, vid_base} : '0;

  vmap_base_reg #(
    .ADDR_W (ADDR_W),
    .RST_VAL(VID_RST_BASE)
  ) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(base_wr),
    .wdata_i(wdata_i[ADDR_W-1:0]),
    .base_o (vid_base)
  );

  vmap_region_dec #(
    .ADDR_W   (ADDR_W),
    .IO_AW    (IO_AW),
    .VID_BYTES(VID_BYTES)
  ) u_dec (
    .req_i    (req_i),
    .addr_i   (addr_i),
    .base_i   (vid_base),
    .region_o (region),
    .vid_off_o(vid_off_o)
  );

  vmap_alias #(
    .ADDR_W(ADDR_W),
    .MEM_AW(MEM_AW)
  ) u_alias (
    .addr_i    (addr_i),
    .mem_addr_o(mem_addr_o)
  );

  assign io_sel_o  = (region == RG_IO);
  assign vid_sel_o = (region == RG_VID);
  assign mem_sel_o = (region == RG_MEM);
endmodule

// File: rtl/vmap_decoder_chk.sv
module vmap_decoder_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned MEM_AW = 20,
  parameter int unsigned IO_AW  = 12,
  parameter logic [ADDR_W-1:0] BASE_REG_ADDR = 24'hFFFFE0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] wdata_i,
  input logic              io_sel_i,
  input logic              vid_sel_i,
  input logic              mem_sel_i,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic [ADDR_W-1:0] base_i
);
  logic base_wr_seen;
  assign base_wr_seen = req_i && we_i && (addr_i == BASE_REG_ADDR);

  AST_ONE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({io_sel_i, vid_sel_i, mem_sel_i}));                           // R5
  AST_IDLE_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> !(io_sel_i || vid_sel_i || mem_sel_i));                     // R5
  AST_IO_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (&addr_i[ADDR_W-1:IO_AW])) |-> io_sel_i);                    // R2
  AST_MEM_ALIASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sel_i |-> (mem_addr_i[ADDR_W-1:MEM_AW] == '0 &&
                   mem_addr_i[MEM_AW-1:0] == addr_i[MEM_AW-1:0]));         // R4
  AST_BASE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_wr_seen |=> (base_i == $past(wdata_i)));                          // R6
  AST_BASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !base_wr_seen |=> $stable(base_i));                                    // R8
endmodule

bind vmap_decoder vmap_decoder_chk #(
  .ADDR_W       (ADDR_W),
  .MEM_AW       (MEM_AW),
  .IO_AW        (IO_AW),
  .BASE_REG_ADDR(BASE_REG_ADDR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i[ADDR_W-1:0]),
  .io_sel_i  (io_sel_o),
  .vid_sel_i (vid_sel_o),
  .mem_sel_i (mem_sel_o),
  .mem_addr_i(mem_addr_o),
  .base_i    (vid_base)
);

// File: tb/vmap_decoder_tb.sv
`timescale 1ns/1ps
module vmap_decoder_tb;
  localparam int unsigned AW = 24;
  localparam int unsigned DW = 32;
  localparam int unsigned VB = 98304;
  localparam logic [AW-1:0] REG_A = 24'hFFFFE0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          io_sel, vid_sel, mem_sel, base_hit;
  logic [16:0]   vid_off;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] base_rdata;

  int unsigned n_vec = 0, n_bad = 0;
  logic [AW-1:0] base_m;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vmap_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .io_sel_o(io_sel), .vid_sel_o(vid_sel),
    .vid_off_o(vid_off), .mem_sel_o(mem_sel), .mem_addr_o(mem_addr),
    .base_hit_o(base_hit), .base_rdata_o(base_rdata)
  );

  function automatic bit exp_io(input logic r, input logic [AW-1:0] a);
    return r && (a[23:12] == 12'hFFF);
  endfunction

  function automatic bit exp_vid(input logic r, input logic [AW-1:0] a,
                                 input logic [AW-1:0] b);
    longint d;
    d = longint'(a) - longint'(b);
    return r && !exp_io(r, a) && d >= 0 && d < VB;
  endfunction

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic r, input logic w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string tag);
    bit e_io, e_vid, e_mem, e_hit;
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d;
    #1;
    n_vec++;
    e_io  = exp_io(r, a);
    e_vid = exp_vid(r, a, base_m);
    e_mem = r && !e_io && !e_vid;
    e_hit = r && (a == REG_A);
    chk(tag, "io_sel", io_sel, e_io);
    chk(tag, "vid_sel", vid_sel, e_vid);
    chk(tag, "mem_sel", mem_sel, e_mem);
    if (e_vid) chk(tag, "vid_off", vid_off, longint'(a - base_m) & 'h1FFFF);
    if (e_mem) chk(tag, "mem_addr", mem_addr, {4'h0, a[19:0]});
    chk(tag, "base_hit", base_hit, e_hit);
    chk(tag, "base_rdata", base_rdata, e_hit ? {8'h0, base_m} : 32'h0);
    if (e_hit && w && rst_n) base_m = d[AW-1:0];
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'h5EED_0A11));
    base_m = 24'h0E7F00;
    // R1 reset value, R5 idle during reset
    apply(1'b0, 1'b0, 24'h000100, '0, "R5");
    apply(1'b1, 1'b0, REG_A, '0, "R1");
    #3 rst_n = 1'b1;
    apply(1'b1, 1'b0, REG_A, '0, "R1");
    apply(1'b0, 1'b1, REG_A, 32'h00123400, "R5");
    // R3 window edges at the default base
    apply(1'b1, 1'b0, 24'h0E7EFF, '0, "R4");
    apply(1'b1, 1'b0, 24'h0E7F00, '0, "R3");
    apply(1'b1, 1'b1, 24'h0FFEFF, '0, "R3");
    apply(1'b1, 1'b0, 24'h0FFF00, '0, "R4");
    // R4 aliasing of high addresses
    apply(1'b1, 1'b0, 24'h5ABCDE, '0, "R4");
    apply(1'b1, 1'b0, 24'hFFEFFF, '0, "R4");
    // R2 lowest I/O address
    apply(1'b1, 1'b1, 24'hFFF000, 32'hDEAD, "R2");
    // R8 read of the register and writes elsewhere keep the base
    apply(1'b1, 1'b1, 24'hFFFFE4, 32'h00900000, "R8");
    apply(1'b1, 1'b0, REG_A, 32'h00900000, "R8");
    apply(1'b1, 1'b0, REG_A, '0, "R8");
    // R6 relocate above 8 MB, used on the very next cycle
    apply(1'b1, 1'b1, REG_A, 32'hAB900000, "R6");
    apply(1'b1, 1'b0, 24'h900000, '0, "R6");
    apply(1'b1, 1'b0, REG_A, '0, "R7");
    apply(1'b1, 1'b0, 24'h917FFF, '0, "R3");
    apply(1'b1, 1'b0, 24'h918000, '0, "R4");
    // R9 whole low 8 MB is memory now
    apply(1'b1, 1'b0, 24'h0E7F00, '0, "R9");
    apply(1'b1, 1'b0, 24'h7FFFFF, '0, "R9");
    apply(1'b1, 1'b0, 24'h000000, '0, "R9");
    // R2 window overlapping the I/O space
    apply(1'b1, 1'b1, REG_A, 32'h00FFE800, "R6");
    apply(1'b1, 1'b0, 24'hFFEFFF, '0, "R3");
    apply(1'b1, 1'b0, 24'hFFF010, '0, "R2");
    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int unsigned k;
      k = $urandom % 8;
      case (k)
        0: begin
          a = $urandom;
          if ($urandom % 2) a = a & 24'h0FFF00;
          apply(1'b1, 1'b1, REG_A, {8'h0, a}, "R6");
        end
        1: apply(1'b1, 1'b0, REG_A, $urandom, "R7");
        2: apply(1'b1, 1'($urandom), {12'hFFF, 12'($urandom)}, $urandom, "R2");
        3, 4: apply(1'b1, 1'($urandom),
                    base_m + AW'($urandom % (VB + 64)) - AW'(32), $urandom, "R3");
        5: apply(1'b0, 1'($urandom), AW'($urandom), $urandom, "R5");
        default: apply(1'b1, 1'($urandom), AW'($urandom), $urandom, "R4");
      endcase
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule